// File: doc/BRIEF.md
# Synchronised Switch Debounce Filter

This block cleans up one noisy, asynchronous switch or reset line before the rest of a chip uses it. The raw level first goes through a short chain of flip-flops clocked by the system clock, which contains metastability. A filter then drives a registered clean level. That level changes only after the synchronised input has shown the opposite value on every clock edge for a programmable number of cycles.

The hold time is a parameter given in clock cycles. At a 50 MHz clock, a 30 ms window is 1,500,000 cycles. A simulation can set a small value instead. The filter treats both directions alike, so a pulse that gets through is never shorter than the hold time. Because the committed level is always the one proven over the whole window, an input that flips on the very edge where the window would close is never taken up.

Top module: `sync_debounce`

## Requirements
- R1: The raw input passes through two cascaded flip-flops before the filter sees it. With a hold time of H cycles, a new level that is first sampled at clock edge 1 appears on `clean_out` right after edge H+2, and not after edge H+1.
- R2: `clean_out` goes from 0 to 1 only after the synchronised input has been 1 on H consecutive filter edges.
- R3: `clean_out` goes from 1 to 0 only after the synchronised input has been 0 on H consecutive filter edges.
- R4: When the synchronised input returns to the current output level, the stability count restarts from zero. Cycles that were counted before the interruption do not count toward a later commit.
- R5: A run of H-1 samples followed by the old level on the sample that would complete the window leaves `clean_out` unchanged. This holds in both directions.
- R6: `clean_out` comes straight from a flip-flop, and once high it stays high for at least H cycles.
- R7: While `rst_n` is 0 on a rising clock edge (synchronous, active low), `clean_out` and every synchroniser and counter flop are cleared. After release, a high input needs a full H-cycle window, plus the synchroniser delay, before `clean_out` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all flops use its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| raw_in | input | 1 | Unsynchronised noisy level from the switch |
| clean_out | output | 1 | Filtered level, driven by a flop |

## Verification
Counting the first rising edge that samples a new raw level as edge 1, a committed change is due right after edge H+2. A reset clears `clean_out` right after the edge on which `rst_n` is first seen low. A restart after reset release commits right after edge H+1, counting the release edge as edge 0. The bench keeps a global edge counter. Each stimulus task records the edge on which its first sample lands and queues the expected level for the cycle just before the commit and for the commit cycle itself. For an interrupted window, it queues the expected level at and past the point where a commit would otherwise fall. A monitor compares the output at the falling edge that follows each of those rising edges, so every check lands half a cycle after the flop has settled.

// File: rtl/debounce_pkg.sv
// Package: debounce_pkg
// Shared helpers for the debounce filter. It assumes nothing beyond
// elaboration-time integer arithmetic.
package debounce_pkg;

    // Width of a counter that must reach n-1; never less than one bit.
    function automatic int count_width(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    // Width of a counter that must reach n itself (saturating monitors).
    function automatic int sat_width(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/db_sync_chain.sv
// Module: db_sync_chain
// A cascade of STAGES flops that carries an asynchronous level into the
// clk domain. It assumes STAGES >= 1 and that the input is one bit wide.
// Every flop clears under the synchronous active-low reset.
module db_sync_chain #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] taps;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // Purpose: first capture of the asynchronous level.
            always_ff @(posedge clk) begin
                if (!rst_n) taps[0] <= 1'b0;
                else        taps[0] <= async_in;
            end
        end else begin : g_next
            // Purpose: one more settling stage.
            always_ff @(posedge clk) begin
                if (!rst_n) taps[i] <= 1'b0;
                else        taps[i] <= taps[i-1];
            end
        end
    end

    assign sync_out = taps[STAGES-1];

endmodule

// File: rtl/db_hold_timer.sv
// Module: db_hold_timer
// Counts consecutive edges on which `mismatch` is high. It raises `expire`
// on the edge where the HOLD-th consecutive mismatch is seen. Any edge
// without a mismatch clears the count, so an interrupted window starts
// again from zero. It assumes HOLD >= 1.
module db_hold_timer
    import debounce_pkg::*;
#(
    parameter int HOLD = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mismatch,
    output logic expire
);

    localparam int            W    = count_width(HOLD);
    localparam logic [W-1:0]  LAST = W'(HOLD - 1);

    logic [W-1:0] cnt;

    assign expire = mismatch && (cnt == LAST);

    // Purpose: run length of the unproven level; clears on a break or a commit.
    always_ff @(posedge clk) begin
        if (!rst_n || !mismatch || expire) cnt <= '0;
        else                               cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/db_level_reg.sv
// Module: db_level_reg
// Holds the clean level. On `commit` it takes the opposite of its own
// value. That is the level the timer has just proven on every edge of the
// window, and not whatever the input shows at that instant. It assumes
// `commit` only fires while the input differs from the held level.
module db_level_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic commit,
    output logic level
);

    // Purpose: registered output level, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      level <= 1'b0;
        else if (commit) level <= ~level;
    end

endmodule

// File: rtl/sync_debounce.sv
// Module: sync_debounce
// Top of the debounce filter: synchroniser, stability timer and output
// register. It assumes HOLD_CYCLES >= 1 and SYNC_STAGES >= 2. It also
// assumes raw_in may change at any time relative to clk.
module sync_debounce #(
    parameter int HOLD_CYCLES = 1500000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic clean_out
);

    logic sync_lvl;
    logic differs;
    logic window_done;

    db_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_in),
        .sync_out (sync_lvl)
    );

    // Purpose: flag edges where the input disagrees with the held level.
    assign differs = sync_lvl ^ clean_out;

    db_hold_timer #(.HOLD(HOLD_CYCLES)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .mismatch (differs),
        .expire   (window_done)
    );

    db_level_reg u_level (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (window_done),
        .level  (clean_out)
    );

endmodule

// File: rtl/sync_debounce_chk.sv
// Module: sync_debounce_chk
// Property checker bound to sync_debounce. It keeps its own saturating run
// counters of the synchronised input and of the clean level, and checks
// the filter's rules against them.
module sync_debounce_chk
    import debounce_pkg::*;
#(
    parameter int HOLD = 8
) (
    input logic clk,
    input logic rst_n,
    input logic sync_lvl,
    input logic clean
);

    localparam int           SW  = sat_width(HOLD);
    localparam logic [SW-1:0] CAP = SW'(HOLD);

    logic [SW-1:0] hi_run;
    logic [SW-1:0] lo_run;
    logic [SW-1:0] up_len;

    // Purpose: consecutive edges with the synchronised input high / low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run <= '0;
            lo_run <= '0;
        end else begin
            hi_run <= sync_lvl  ? ((hi_run == CAP) ? CAP : hi_run + 1'b1) : '0;
            lo_run <= !sync_lvl ? ((lo_run == CAP) ? CAP : lo_run + 1'b1) : '0;
        end
    end

    // Purpose: consecutive edges with the clean level high.
    always_ff @(posedge clk) begin
        if (!rst_n) up_len <= '0;
        else        up_len <= clean ? ((up_len == CAP) ? CAP : up_len + 1'b1) : '0;
    end

    // R2: a rise needs a full run of high synchronised samples.
    a_r2_rise_after_window: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clean) |-> ($past(sync_lvl) && (int'($past(hi_run)) >= HOLD - 1)));

    // R3: a fall needs a full run of low synchronised samples.
    a_r3_fall_after_window: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clean) |-> (!$past(sync_lvl) && (int'($past(lo_run)) >= HOLD - 1)));

    // R4: agreement between input and output leaves the output alone.
    a_r4_agree_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_lvl == clean) |=> $stable(clean));

    // R6: a high pulse on the output lasts at least HOLD cycles.
    a_r6_min_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clean) |-> (int'($past(up_len)) >= HOLD - 1));

    // R7: a reset edge leaves the output low.
    a_r7_reset_clears: assert property (@(posedge clk)
        !rst_n |=> !clean);

endmodule

bind sync_debounce sync_debounce_chk #(.HOLD(HOLD_CYCLES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_lvl (sync_lvl),
    .clean    (clean_out)
);

// File: tb/sync_debounce_test.sv
`timescale 1ns/1ps
// Bench: scoreboard. Stimulus tasks queue expected levels tagged with an
// absolute edge number; a monitor compares them at falling edges.
module sync_debounce_test;

    localparam int H = 8;

    typedef struct {
        int    cyc;
        logic  val;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic raw = 1'b0;
    logic clean;
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    exp_t q[$];

    sync_debounce #(.HOLD_CYCLES(H), .SYNC_STAGES(2)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw_in    (raw),
        .clean_out (clean)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: cycle %0d clean_out=%b expected=%b", tag, cyc, act, exp);
        end
    endtask

    function automatic void expect_at(input int c, input logic v, input string tag);
        exp_t e;
        e.cyc = c;
        e.val = v;
        e.tag = tag;
        q.push_back(e);
    endfunction

    // Drive a level for n sampling edges; called right after a falling edge.
    task automatic run_level(input logic lvl, input int n);
        raw = lvl;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare queued expectations when their edge has passed.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].cyc <= cyc) begin
            if (q[0].cyc == cyc) check(clean, q[0].val, q[0].tag);
            else begin
                checks++;
                errors++;
                $display("FAIL %s: expectation for cycle %0d missed at %0d (expected %b)",
                         q[0].tag, q[0].cyc, cyc, q[0].val);
            end
            void'(q.pop_front());
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, clean_out=%b expected end of test", clean);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int s;
        int t;
        repeat (3) @(negedge clk);
        check(clean, 1'b0, "R7 reset value");
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(clean, 1'b0, "R7 idle after reset");

        // Exact-length high run, then low: latency, rise, min high, fall.
        s = cyc + 1;
        expect_at(s + H,         1'b0, "R1 not yet after H+1 edges");
        expect_at(s + H + 1,     1'b1, "R2 rise after H+2 edges");
        expect_at(s + 2 * H,     1'b1, "R6 still high before window ends");
        expect_at(s + 2 * H + 1, 1'b0, "R3 fall after low window");
        run_level(1'b1, H);
        run_level(1'b0, 3 * H);

        // Input returns on the completing sample: no rise.
        s = cyc + 1;
        expect_at(s + H + 1, 1'b0, "R5 no rise on expiry change");
        expect_at(s + H + 3, 1'b0, "R5 still low later");
        run_level(1'b1, H - 1);
        run_level(1'b0, 2 * H);

        // Interrupted run: the count restarts from zero.
        run_level(1'b1, H - 2);
        run_level(1'b0, 1);
        t = cyc + 1;
        expect_at(t + H,         1'b0, "R4 earlier samples not counted");
        expect_at(t + H + 1,     1'b1, "R4 rise after fresh window");
        expect_at(t + 2 * H + 1, 1'b0, "R3 fall after restarted rise");
        run_level(1'b1, H);
        run_level(1'b0, 3 * H);

        // Falling side of the expiry rule.
        run_level(1'b1, 2 * H + 2);
        s = cyc + 1;
        expect_at(s + H + 1, 1'b1, "R5 no fall on expiry change");
        expect_at(s + H + 3, 1'b1, "R5 still high later");
        run_level(1'b0, H - 1);
        run_level(1'b1, 2 * H);

        // Reset while high, then a full window after release.
        rst_n = 1'b0;
        expect_at(cyc + 1, 1'b0, "R7 reset clears high output");
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t = cyc + 1;
        expect_at(t + H,     1'b0, "R7 no early rise after release");
        expect_at(t + H + 1, 1'b1, "R7 rise after full window");
        run_level(1'b1, 2 * H);
        run_level(1'b0, 3 * H);

        repeat (4) @(negedge clk);
        if (q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard: %0d expectations left, expected 0", q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule